// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block is the clocked digital front end of an 8-bit segmented current-steering converter. Each clock it captures one input word and turns it into on/off commands for the unit current cells. The upper six bits are treated as a count of large cells. Two small thermometer decoders, one for columns and one for rows, drive local logic in each position of an 8x8 matrix. The two lowest bits stay binary and drive a group of four small cells, each worth a quarter of a large cell. One small cell is a dummy that is never switched on.

Every cell gets a complementary pair of switch commands. All pairs come from one output register stage, so every switch in the array toggles on the same clock edge no matter how long each decode path is. The input word is also registered before decoding. A word captured on one edge is therefore visible on the switch outputs after the following edge.

Top module: `segdac_switch_decoder`

## Requirements
- R1: The input word is split into three fields: `din[7:5]` is the column value C, `din[4:2]` is the row value R, and `din[1:0]` is the low value L.
- R2: The column and row values each pass through a thermometer decoder with seven lines; line i (1..7) is high exactly when the value is at least i.
- R3: Main cell k is addressed as k = 8*c + r (column c, row r, each 0..7). It is enabled exactly when c < C, or when c == C and r < R. As a result, `main_en` equals (1 << (8*C+R)) - 1, a thermometer of the upper six bits.
- R4: `small_en[0]` follows `din[0]`; `small_en[1]` and `small_en[2]` both follow `din[1]`; `small_en[3]` is a dummy and is always 0.
- R5: Each cell has a complementary pair: `main_enb` is always the bitwise inverse of `main_en`, and `small_enb` is always the bitwise inverse of `small_en`. Both halves of a pair come from the same register stage.
- R6: A word presented before clock edge N appears on every output bit after edge N+1. No output bit changes after edge N alone, and all bits change on the same edge.
- R7: While `rst` is high at a rising edge, that edge clears the input register and all enables (`main_en` and `small_en` go to 0, `main_enb` and `small_enb` go to all ones). After `rst` is released, the outputs stay cleared for one more edge.
- R8: The switched weight 4*popcount(`main_en`) + popcount(`small_en`) equals the input word two edges earlier, reaching 255 at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Input code for the converter |
| main_en | output | 64 | Switch-on commands for the matrix cells, index 8*column+row |
| main_enb | output | 64 | Complementary switch commands for the matrix cells |
| small_en | output | 4 | Switch-on commands for the low-segment cells, bit 3 is the dummy |
| small_enb | output | 4 | Complementary switch commands for the low-segment cells |

## Verification
Every output is due exactly two rising edges after the input word is set up, because the word passes the input register and then the output register. The bench changes `din` on a falling edge. One falling edge later it confirms that the whole output still shows the previous word. After the second rising edge it compares the full vectors against a model computed from the requirements. A streaming test changes the word every cycle and compares each sample against the word from two falling edges earlier. The reset tests sample after the reset edge and again on the first edge after release.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    // Default segmentation: column field, row field, binary low field
    localparam int DEF_COL_BITS = 3;
    localparam int DEF_ROW_BITS = 3;
    localparam int DEF_LOW_BITS = 2;

    // One differential switch command pair for a current cell
    typedef struct packed {
        logic on;   // steer current to the positive output
        logic off;  // steer current to the negative output
    } sw_pair_t;

    // Value a pair takes while the cell carries no signal current
    localparam sw_pair_t SW_IDLE = '{on: 1'b0, off: 1'b1};

    function automatic sw_pair_t make_pair(input logic enable);
        sw_pair_t p;
        p.on  = enable;
        p.off = ~enable;
        return p;
    endfunction

endpackage

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
    parameter int BITS = 3
) (
    input  logic [BITS-1:0]        bin,
    output logic [(1<<BITS)-2:0]   th     // bit i is line i+1
);
    localparam int LINES = (1 << BITS) - 1;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign th[i] = ({1'b0, bin} > (BITS+1)'(i));
    end
endmodule

// File: rtl/segdac_cell_matrix.sv
module segdac_cell_matrix #(
    parameter int COL_BITS = 3,
    parameter int ROW_BITS = 3
) (
    input  logic [(1<<COL_BITS)-2:0]             col_th,
    input  logic [(1<<ROW_BITS)-2:0]             row_th,
    output logic [(1<<(COL_BITS+ROW_BITS))-1:0]  cell_on
);
    localparam int NCOL = 1 << COL_BITS;
    localparam int NROW = 1 << ROW_BITS;

    logic [NCOL-1:0] col_full;   // column value above c: whole column on
    logic [NCOL-1:0] col_part;   // column value equals c: row decides
    logic [NROW-1:0] row_more;   // row value above r

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic at_least;
        if (c == 0) begin : g_first
            assign at_least = 1'b1;
        end else begin : g_rest
            assign at_least = col_th[c-1];
        end
        if (c == NCOL-1) begin : g_last
            assign col_full[c] = 1'b0;
        end else begin : g_body
            assign col_full[c] = col_th[c];
        end
        assign col_part[c] = at_least & ~col_full[c];
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        if (r == NROW-1) begin : g_last
            assign row_more[r] = 1'b0;
        end else begin : g_body
            assign row_more[r] = row_th[r];
        end
    end

    // Local logic in every cell position
    for (genvar c = 0; c < NCOL; c++) begin : g_mc
        for (genvar r = 0; r < NROW; r++) begin : g_mr
            assign cell_on[c*NROW + r] = col_full[c] | (col_part[c] & row_more[r]);
        end
    end
endmodule

// File: rtl/segdac_low_seg.sv
module segdac_low_seg #(
    parameter int LOW_BITS = 2
) (
    input  logic [LOW_BITS-1:0]       low,
    output logic [(1<<LOW_BITS)-1:0]  small_on
);
    localparam int NSMALL = 1 << LOW_BITS;

    // Bit b drives 2**b cells starting at index 2**b - 1
    for (genvar b = 0; b < LOW_BITS; b++) begin : g_bit
        for (genvar j = 0; j < (1 << b); j++) begin : g_cell
            assign small_on[(1 << b) - 1 + j] = low[b];
        end
    end
    // Last cell is a matching dummy that never conducts signal current
    assign small_on[NSMALL-1] = 1'b0;
endmodule

// File: rtl/segdac_switch_reg.sv
module segdac_switch_reg
    import segdac_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] on,
    output logic [N-1:0] off
);
    sw_pair_t pair_q [N];

    for (genvar i = 0; i < N; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) pair_q[i] <= SW_IDLE;
            else     pair_q[i] <= make_pair(d[i]);
        end
        assign on[i]  = pair_q[i].on;
        assign off[i] = pair_q[i].off;
    end

    // R5: both halves of every pair are opposite after each edge
    a_r5_pair_complement: assert property (@(posedge clk) disable iff (rst)
        (on ^ off) == {N{1'b1}})
        else $error("R5 switch pair not complementary");
endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder
    import segdac_pkg::*;
#(
    parameter int COL_BITS = DEF_COL_BITS,
    parameter int ROW_BITS = DEF_ROW_BITS,
    parameter int LOW_BITS = DEF_LOW_BITS,
    localparam int WORD_W  = COL_BITS + ROW_BITS + LOW_BITS,
    localparam int NMAIN   = 1 << (COL_BITS + ROW_BITS),
    localparam int NSMALL  = 1 << LOW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    output logic [NMAIN-1:0]  main_en,
    output logic [NMAIN-1:0]  main_enb,
    output logic [NSMALL-1:0] small_en,
    output logic [NSMALL-1:0] small_enb
);
    localparam int NCOL = 1 << COL_BITS;
    localparam int NROW = 1 << ROW_BITS;
    localparam int UNIT = NSMALL;   // small-cell units per main cell

    typedef struct packed {
        logic [COL_BITS-1:0] col;
        logic [ROW_BITS-1:0] row;
        logic [LOW_BITS-1:0] low;
    } seg_word_t;

    seg_word_t word_q;

    // R1: input register, field split by position
    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= seg_word_t'(din);
    end

    logic [NCOL-2:0]   col_th;
    logic [NROW-2:0]   row_th;
    logic [NMAIN-1:0]  main_d;
    logic [NSMALL-1:0] small_d;

    segdac_therm_dec #(.BITS(COL_BITS)) u_col_dec (.bin(word_q.col), .th(col_th));
    segdac_therm_dec #(.BITS(ROW_BITS)) u_row_dec (.bin(word_q.row), .th(row_th));

    segdac_cell_matrix #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_matrix (
        .col_th  (col_th),
        .row_th  (row_th),
        .cell_on (main_d)
    );

    segdac_low_seg #(.LOW_BITS(LOW_BITS)) u_low (
        .low      (word_q.low),
        .small_on (small_d)
    );

    segdac_switch_reg #(.N(NMAIN)) u_main_reg (
        .clk (clk), .rst (rst), .d (main_d), .on (main_en), .off (main_enb)
    );

    segdac_switch_reg #(.N(NSMALL)) u_small_reg (
        .clk (clk), .rst (rst), .d (small_d), .on (small_en), .off (small_enb)
    );

    // Edges since reset, used only to arm the weight check
    logic [1:0] chk_age;
    always_ff @(posedge clk) begin
        if (rst)                 chk_age <= 2'd0;
        else if (chk_age != 2'd2) chk_age <= chk_age + 2'd1;
    end

    // R7: a reset edge leaves every cell idle
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (main_en == '0 && small_en == '0 &&
                 main_enb == '1 && small_enb == '1))
        else $error("R7 outputs not idle after reset");

    // R3: enabled main cells always form a contiguous run from index 0
    a_r3_main_therm: assert property (@(posedge clk) disable iff (rst)
        (main_en & (main_en + NMAIN'(1))) == '0)
        else $error("R3 main enables not thermometer shaped");

    // R4: the dummy small cell never conducts
    a_r4_dummy_off: assert property (@(posedge clk) disable iff (rst)
        !small_en[NSMALL-1] && small_enb[NSMALL-1])
        else $error("R4 dummy cell switched");

    // R8 and R6: switched weight equals the word from two edges back
    a_r8_weight: assert property (@(posedge clk) disable iff (rst)
        (chk_age == 2'd2) |->
        ($countones(main_en) * UNIT + $countones(small_en)) == int'($past(din, 2)))
        else $error("R8 switched weight mismatch");
endmodule

// File: tb/segdac_switch_decoder_bench.sv
module segdac_switch_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  din = 8'd0;
    logic [63:0] main_en, main_enb;
    logic [3:0]  small_en, small_enb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    segdac_switch_decoder u_segdac_switch_decoder (
        .clk (clk), .rst (rst), .din (din),
        .main_en (main_en), .main_enb (main_enb),
        .small_en (small_en), .small_enb (small_enb)
    );

    function automatic logic [63:0] exp_main(input logic [7:0] v);
        return (64'd1 << v[7:2]) - 64'd1;
    endfunction

    function automatic logic [3:0] exp_small(input logic [7:0] v);
        return {1'b0, v[1], v[1], v[0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output with the model of word v
    task automatic check_word(input string req, input logic [7:0] v);
        check({req, " main"},  main_en,            exp_main(v));
        check({req, " small"}, {60'd0, small_en},  {60'd0, exp_small(v)});
        check("R5 main pair",  main_enb,           ~main_en);
        check("R5 small pair", {60'd0, small_enb}, {60'd0, ~small_en});
    endtask

    task automatic apply(input logic [7:0] v);
        @(negedge clk) din = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        din = 8'hFF;
        repeat (3) @(negedge clk);
        check("R7 reset main",   main_en,            64'd0);
        check("R7 reset mainb",  main_enb,           {64{1'b1}});
        check("R7 reset small",  {60'd0, small_en},  64'd0);
        check("R7 reset smallb", {60'd0, small_enb}, 64'hF);
        rst = 1'b0;
        @(negedge clk);   // word loaded, outputs still cleared
        check("R7 idle one edge after release", main_en, 64'd0);
        @(negedge clk);
        check_word("R7 first word after release", 8'hFF);
    endtask

    task automatic t_sweep();
        for (int v = 0; v < 256; v++) begin
            apply(8'(v));
            check_word("R3 R4 sweep", 8'(v));
            checks++;
            if ($countones(main_en) * 4 + $countones(small_en) != v) begin
                errors++;
                $display("FAIL R8 weight actual=%0d expected=%0d",
                         $countones(main_en) * 4 + $countones(small_en), v);
            end
        end
    endtask

    task automatic t_corners();
        // R1 R2: column only, row only, low only
        apply(8'b001_000_00); check_word("R1 col=1",        8'b001_000_00);
        check("R3 column 0 full", main_en, 64'h0000_0000_0000_00FF);
        apply(8'b000_001_00); check_word("R2 row=1",        8'b000_001_00);
        check("R3 one cell", main_en, 64'h1);
        apply(8'b111_111_11); check_word("R8 full scale",   8'hFF);
        check("R4 dummy off full scale", {63'd0, small_en[3]}, 64'd0);
        apply(8'b111_000_00); check_word("R3 col=7 row=0",  8'b111_000_00);
        apply(8'b011_110_10); check_word("R2 mixed",        8'b011_110_10);
        apply(8'b000_000_01); check_word("R4 bit0 only",    8'b000_000_01);
        apply(8'b000_000_10); check_word("R4 bit1 only",    8'b000_000_10);
    endtask

    task automatic t_latency();
        logic [7:0] prev;
        prev = 8'h3C;
        apply(prev);
        @(negedge clk) din = 8'hC3;
        @(negedge clk);   // one edge later: nothing may have moved
        check_word("R6 old after one edge", prev);
        @(negedge clk);
        check_word("R6 new after two edges", 8'hC3);
        @(negedge clk) din = 8'h00;
        @(negedge clk);
        check_word("R6 old after one edge", 8'hC3);
        @(negedge clk);
        check_word("R6 all off after two edges", 8'h00);
    endtask

    task automatic t_stream();
        logic [7:0] hist [2];
        hist[0] = din;
        hist[1] = din;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i >= 2) check_word("R6 stream", hist[1]);
            hist[1] = hist[0];
            din = 8'((i * 37 + 11) ^ (i << 3));
            hist[0] = din;
        end
    endtask

    task automatic t_reset_mid();
        apply(8'hA5);
        @(negedge clk) begin din = 8'h5A; rst = 1'b1; end
        @(negedge clk);
        check_word("R7 mid reset clears", 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check_word("R7 hold cleared after release", 8'h00);
        @(negedge clk);
        check_word("R7 resume", 8'h5A);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_corners();
        t_latency();
        t_stream();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule